// File: doc/BRIEF.md
# Binary Tape Section Loader

The block reads a stream of 8-bit tape frames in the compact binary loader format and turns it into memory writes. Two consecutive frames carry one 12-bit word. The first frame of a pair holds the upper six bits and the second frame holds the lower six. The block writes into an external memory of up to eight fields of 4096 words each. It drives a 3-bit field, a 12-bit address, 12-bit data and a write strobe. Serial reception and the memory are outside the block.

A tape may contain several sections separated by leader. Each pulse on `start` loads one section. The block holds every data word back by one pair, because the last word of a section is a checksum and must not reach memory. When trailer arrives, the block compares the held word against its running sum. It then raises `done`, raises `err` on a mismatch, and shows the difference on `csum_diff`, where zero means the load was good.

The state machine has four states:
- `ST_IDLE` waits for `start` and moves to `ST_LEAD`.
- `ST_LEAD` skips leader. It accepts field frames, and the first frame of a pair moves it to `ST_LO`.
- `ST_LO` takes any frame as the second half of a pair and returns to `ST_HI`.
- `ST_HI` accepts field frames. The first frame of a pair moves it to `ST_LO`, and a trailer frame ends the section and returns to `ST_IDLE`.

Top module: `bin_tape_loader`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_we` are all 0.
- R2: A `start` pulse while idle clears the field and address to 0 and sets `busy` in the next cycle. A `start` while busy has no effect, and frames that arrive while idle are ignored.
- R3: A frame with bit 7 = 1 and bit 6 = 0 is a gap frame. Gap frames before the first pair are skipped and add nothing to the checksum.
- R4: A frame with bits 7 and 6 both set is a field frame. It sets the field from bits 5:3 for later data, and it is not counted in the checksum.
- R5: A pair whose first frame has bit 7 = 0 and bit 6 = 1 loads the address pointer with {first[5:0], second[5:0]}.
- R6: A pair whose first frame has bits 7 and 6 clear is data. It is stored with the current field and address, and the pointer then increments. The word appears on `mem_*` with `mem_we` high for one cycle, one cycle after the second frame of the following pair.
- R7: The pointer wraps from 7777 octal to 0000 and leaves the field unchanged.
- R8: The last data pair before the trailer is the checksum word and is never written.
- R9: A gap frame in `ST_HI` ends the section. In the next cycle `done` = 1, `busy` = 0, and `csum_diff` = (12-bit sum of all pair frame bytes other than the checksum pair) − (checksum word). `err` is set exactly when `csum_diff` is nonzero.
- R10: If no data pair is held when the trailer arrives, `err` = 1 and `csum_diff` equals the full sum.
- R11: `done`, `err` and `csum_diff` hold until the next `start`, which clears them.
- R12: When a held word is flushed in the same cycle that a new address, or a new data word with a new field, takes effect, the flushed word keeps the field and address it was captured with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin loading one section |
| frame_valid | input | 1 | A frame is present this cycle |
| frame | input | 8 | Tape frame |
| busy | output | 1 | A section is being loaded |
| done | output | 1 | The section has ended |
| err | output | 1 | Checksum mismatch, or checksum missing |
| csum_diff | output | 12 | Running sum minus the checksum word |
| mem_we | output | 1 | Memory write strobe |
| mem_field | output | 3 | Field of the write |
| mem_addr | output | 12 | Address of the write |
| mem_data | output | 12 | Data word |

## Verification
The delicate overlap is a flush of the held data word in the same cycle that an address pair loads the pointer, or that a data word captured under a newly set field takes its place. The bench provokes both cases. It ends a data run directly with an address pair, and it inserts a field frame between two data pairs. The scoreboard then requires each flushed write to carry the field and address that held when its own pair arrived. The same overlap decides the checksum: a trailer must discard the held word instead of writing it.

// File: rtl/bt_pkg.sv
package bt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HI,
        ST_LO
    } st_t;

    typedef enum logic [1:0] {
        FK_DATA,
        FK_ADDR,
        FK_FIELD,
        FK_GAP
    } fkind_t;
endpackage

// File: rtl/bt_frame_decode.sv
module bt_frame_decode
    import bt_pkg::*;
#(
    parameter int HALF_W  = 6,
    parameter int FIELD_W = 3
) (
    input  logic [HALF_W+1:0]  frame,
    output fkind_t             kind,
    output logic [FIELD_W-1:0] fld
);
    localparam int TOP_BIT = HALF_W + 1;
    localparam int SUB_BIT = HALF_W;

    always_comb begin
        unique case ({frame[TOP_BIT], frame[SUB_BIT]})
            2'b11:   kind = FK_FIELD;
            2'b10:   kind = FK_GAP;
            2'b01:   kind = FK_ADDR;
            default: kind = FK_DATA;
        endcase
    end

    assign fld = frame[HALF_W-1 -: FIELD_W];
endmodule

// File: rtl/bt_csum.sv
module bt_csum #(
    parameter int SUM_W  = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [BYTE_W-1:0] add_byte,
    output logic [SUM_W-1:0]  sum
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (add_en) begin
            sum <= sum + SUM_W'(add_byte);
        end
    end
endmodule

// File: rtl/bt_ptr.sv
module bt_ptr #(
    parameter int FIELD_W = 3,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               fld_ld,
    input  logic [FIELD_W-1:0] fld_in,
    input  logic               addr_ld,
    input  logic [ADDR_W-1:0]  addr_in,
    input  logic               inc,
    output logic [FIELD_W-1:0] field,
    output logic [ADDR_W-1:0]  addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field <= '0;
        end else if (clr) begin
            field <= '0;
        end else if (fld_ld) begin
            field <= fld_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clr) begin
            addr <= '0;
        end else if (addr_ld) begin
            addr <= addr_in;
        end else if (inc) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/bin_tape_loader.sv
module bin_tape_loader
    import bt_pkg::*;
#(
    parameter int HALF_W  = 6,
    parameter int FIELD_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  frame_valid,
    input  logic [HALF_W+1:0]     frame,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [2*HALF_W-1:0]   csum_diff,
    output logic                  mem_we,
    output logic [FIELD_W-1:0]    mem_field,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic [2*HALF_W-1:0]   mem_data
);
    localparam int FRAME_W  = HALF_W + 2;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int ADDR_BIT = HALF_W;

    st_t                 state_q, state_d;
    fkind_t              kind;
    logic [FIELD_W-1:0]  fld_new;
    logic [FRAME_W-1:0]  hi_q;
    logic                pend_vld_q;
    logic [WORD_W-1:0]   pend_bytes_q;
    logic [WORD_W-1:0]   pend_word_q;
    logic [FIELD_W-1:0]  pend_field_q;
    logic [WORD_W-1:0]   pend_addr_q;
    logic [WORD_W-1:0]   sum;
    logic [FIELD_W-1:0]  cur_field;
    logic [WORD_W-1:0]   cur_addr;
    logic [WORD_W-1:0]   word_new;
    logic [WORD_W-1:0]   net_diff;
    logic                in_body, open_pair, take_pair, set_fld, end_sec, begin_sec;
    logic                is_addr_pair;

    bt_frame_decode #(.HALF_W(HALF_W), .FIELD_W(FIELD_W)) u_dec (
        .frame (frame),
        .kind  (kind),
        .fld   (fld_new)
    );

    assign in_body      = frame_valid && (state_q == ST_LEAD || state_q == ST_HI);
    assign open_pair    = in_body && (kind == FK_DATA || kind == FK_ADDR);
    assign set_fld      = in_body && (kind == FK_FIELD);
    assign end_sec      = frame_valid && (state_q == ST_HI) && (kind == FK_GAP);
    assign take_pair    = frame_valid && (state_q == ST_LO);
    assign begin_sec    = start && (state_q == ST_IDLE);
    assign is_addr_pair = hi_q[ADDR_BIT];
    assign word_new     = {hi_q[HALF_W-1:0], frame[HALF_W-1:0]};

    bt_csum #(.SUM_W(WORD_W), .BYTE_W(FRAME_W)) u_csum (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (begin_sec),
        .add_en   (open_pair || take_pair),
        .add_byte (frame),
        .sum      (sum)
    );

    bt_ptr #(.FIELD_W(FIELD_W), .ADDR_W(WORD_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (begin_sec),
        .fld_ld  (set_fld),
        .fld_in  (fld_new),
        .addr_ld (take_pair && is_addr_pair),
        .addr_in (word_new),
        .inc     (take_pair && !is_addr_pair),
        .field   (cur_field),
        .addr    (cur_addr)
    );

    assign net_diff = sum - pend_bytes_q - pend_word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (begin_sec) state_d = ST_LEAD;
            ST_LEAD: if (open_pair) state_d = ST_LO;
            ST_HI: begin
                if (end_sec)        state_d = ST_IDLE;
                else if (open_pair) state_d = ST_LO;
            end
            ST_LO:   if (frame_valid) state_d = ST_HI;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy = (state_q != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we       <= 1'b0;
            mem_field    <= '0;
            mem_addr     <= '0;
            mem_data     <= '0;
            done         <= 1'b0;
            err          <= 1'b0;
            csum_diff    <= '0;
            hi_q         <= '0;
            pend_vld_q   <= 1'b0;
            pend_bytes_q <= '0;
            pend_word_q  <= '0;
            pend_field_q <= '0;
            pend_addr_q  <= '0;
        end else begin
            mem_we <= 1'b0;
            if (begin_sec) begin
                done       <= 1'b0;
                err        <= 1'b0;
                csum_diff  <= '0;
                pend_vld_q <= 1'b0;
            end
            if (open_pair) begin
                hi_q <= frame;
            end
            if (take_pair) begin
                if (pend_vld_q) begin
                    mem_we    <= 1'b1;
                    mem_field <= pend_field_q;
                    mem_addr  <= pend_addr_q;
                    mem_data  <= pend_word_q;
                end
                if (is_addr_pair) begin
                    pend_vld_q <= 1'b0;
                end else begin
                    pend_vld_q   <= 1'b1;
                    pend_word_q  <= word_new;
                    pend_field_q <= cur_field;
                    pend_addr_q  <= cur_addr;
                    pend_bytes_q <= WORD_W'(hi_q) + WORD_W'(frame);
                end
            end
            if (end_sec) begin
                done <= 1'b1;
                if (pend_vld_q) begin
                    csum_diff <= net_diff;
                    err       <= (net_diff != '0);
                end else begin
                    csum_diff <= sum;
                    err       <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bt_loader_chk.sv
module bt_loader_chk #(
    parameter int WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [WORD_W-1:0] csum_diff,
    input logic              mem_we
);
    AST_WE_IN_SECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R6

    AST_WE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R6

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9

    AST_PASS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (csum_diff == '0)); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done && !err)); // R11

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err) && $stable(csum_diff))); // R11
endmodule

bind bin_tape_loader bt_loader_chk #(.WORD_W(2*HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .csum_diff (csum_diff),
    .mem_we    (mem_we)
);

// File: tb/bin_tape_loader_tb.sv
module bin_tape_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frame_valid = 1'b0;
    logic [7:0]  frame = '0;
    logic        busy, done, err, mem_we;
    logic [11:0] csum_diff, mem_addr, mem_data;
    logic [2:0]  mem_field;

    int n_tests = 0;
    int n_fail  = 0;
    int n_wr    = 0;
    int n_exp   = 0;
    bit finished = 0;

    logic [26:0] exp_q[$];

    logic [11:0] m_sum, m_addr, m_pbytes, m_pword;
    logic [2:0]  m_field;
    bit          m_pv;
    logic [26:0] m_pend;

    always #2 clk = ~clk;

    bin_tape_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_valid(frame_valid),
        .frame(frame), .busy(busy), .done(done), .err(err), .csum_diff(csum_diff),
        .mem_we(mem_we), .mem_field(mem_field), .mem_addr(mem_addr), .mem_data(mem_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected writes
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                chk(0, "R8 unexpected write", {5'd0, mem_field, mem_addr, mem_data}, 0);
            end else begin
                logic [26:0] e;
                e = exp_q.pop_front();
                chk({mem_field, mem_addr, mem_data} == e, "R6 write field/addr/data",
                    {5'd0, mem_field, mem_addr, mem_data}, {5'd0, e});
            end
        end
    end

    task automatic send(input logic [7:0] b);
        frame = b;
        frame_valid = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
    endtask

    task automatic do_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_sum = 0; m_addr = 0; m_field = 0; m_pv = 0;
    endtask

    task automatic put_field(input logic [2:0] f);
        send({2'b11, f, 3'b000});
        m_field = f;
    endtask

    task automatic put_pair(input bit is_addr, input logic [11:0] w);
        logic [7:0] hi, lo;
        hi = {1'b0, is_addr, w[11:6]};
        lo = {2'b00, w[5:0]};
        send(hi);
        send(lo);
        m_sum = m_sum + 12'(hi) + 12'(lo);
        if (m_pv) begin
            exp_q.push_back(m_pend);
            n_exp++;
        end
        if (is_addr) begin
            m_addr = w;
            m_pv = 0;
        end else begin
            m_pend = {m_field, m_addr, w};
            m_pbytes = 12'(hi) + 12'(lo);
            m_pword = w;
            m_pv = 1;
            m_addr = m_addr + 1'b1;
        end
    endtask

    task automatic end_section(input string tag);
        logic [11:0] ediff;
        bit eerr;
        send(8'h80);
        if (m_pv) begin
            ediff = m_sum - m_pbytes - m_pword;
            eerr = (ediff != 0);
        end else begin
            ediff = m_sum;
            eerr = 1;
        end
        chk(done == 1'b1, {tag, " done"}, done, 1);
        chk(busy == 1'b0, {tag, " busy"}, busy, 0);
        chk(err == eerr, {tag, " err"}, err, eerr);
        chk(csum_diff == ediff, {tag, " csum_diff"}, csum_diff, ediff);
        chk(exp_q.size() == 0, "R8 pending writes left", exp_q.size(), 0);
        send(8'h80);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(done == 0, "R1 done", done, 0);
        chk(err == 0, "R1 err", err, 0);
        chk(mem_we == 0, "R1 mem_we", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 frames while idle ignored
        send(8'h05);
        send(8'h41);
        chk(busy == 0, "R2 idle frames", busy, 0);
        do_start();
        chk(busy == 1, "R2 start", busy, 1);

        // R3 leader skipped
        send(8'h80); send(8'h80); send(8'h80);
        // R4 field frame
        put_field(3'd2);
        put_pair(1, 12'o0100);          // R5
        put_pair(0, 12'o1234);
        put_pair(0, 12'o4321);
        // R2 start while busy ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(busy == 1 && done == 0, "R2 start while busy", {busy, done}, 2'b10);
        put_pair(0, 12'o7070);
        put_pair(1, 12'o2000);          // R12 flush with address load
        put_pair(0, 12'o0011);
        put_field(3'd5);                // R12 flush under new field
        put_pair(0, 12'o0022);
        put_pair(1, 12'o7776);          // R7 wrap
        put_pair(0, 12'o0001);
        put_pair(0, 12'o0002);
        put_pair(0, 12'o0003);
        put_pair(0, m_sum);             // R8 checksum word
        end_section("R9 good tape");

        // R11 result held while idle
        send(8'h12); send(8'h34);
        chk(done == 1 && err == 0, "R11 hold", {done, err}, 2'b10);
        do_start();
        chk(done == 0 && err == 0, "R11 start clears", {done, err}, 2'b00);

        // R9 bad checksum
        send(8'h80);
        put_pair(1, 12'o0400);
        put_pair(0, 12'o5555);
        put_pair(0, m_sum + 12'd5);
        end_section("R9 bad checksum");
        chk(csum_diff == 12'hFFB, "R9 diff value", csum_diff, 12'hFFB);

        // R10 section ending in an address pair
        do_start();
        put_pair(1, 12'o0300);
        put_pair(0, 12'o0017);
        put_pair(1, 12'o0301);
        end_section("R10 no checksum");

        @(negedge clk);
        chk(n_wr == n_exp, "R6 write count", n_wr, n_exp);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule